// File: doc/BRIEF.md
# Activation-Count Victim Row Refresher

This block sits next to the command path of one DRAM bank and watches every row-activate command sent to it. It keeps a saturating activation counter for each row of the bank. All counters are wiped when a programmable maintenance window of clock cycles runs out. The window is tumbling: it restarts from zero each time it expires.

A request is raised in two cases. When one row's own count reaches the programmable threshold, that row is treated as an aggressor, and both of its physical neighbours are requested for a targeted refresh. When the counts of the two rows on either side of a row add up to the threshold, that middle row is requested as the victim of two-sided hammering. Requests wait in a small queue and leave one at a time, each carrying a row address, over a valid/ready handshake. The controller that owns the bank turns each request into a refresh of that row.

Activations addressed to another bank, or to a row number past the end of the bank, are ignored. Neighbour addresses that would fall outside the bank are never produced.

Top module: `row_refresh_guard`

## Requirements
- R1: An activation with `act_bank` equal to `BANK_ID` and `act_row` below `NUM_ROWS` increments that row's counter. In the cycle where the new count is greater than or equal to `cfg_threshold`, rows N-1 and N+1 are queued, N-1 ahead of N+1.
- R2: When a row's own count triggers, that counter returns to zero. The next `cfg_threshold`-1 activations of that row queue nothing, and the one after them triggers again.
- R3: Row 0 queues only row 1. Row `NUM_ROWS`-1 queues only row `NUM_ROWS`-2. No request ever carries a row number of `NUM_ROWS` or more.
- R4: An activation of row N that does not reach the threshold on its own is checked against both neighbours. Row V (V = N-1 or N+1) is queued when count(V-1) + count(V+1) after the activation reaches `cfg_threshold`, with a missing row counting as zero. The counters of both of V's neighbours are then cleared.
- R5: Activations whose `act_bank` differs from `BANK_ID`, or whose `act_row` is `NUM_ROWS` or more, change no counter and queue nothing.
- R6: A window counter expires once every `cfg_window` cycles after reset, and every activation counter is zero at that point. An activation in the cycle of expiry counts as the first of the new window.
- R7: Counters stop at 2^`CNT_W`-1 instead of wrapping. `cfg_threshold` is `CNT_W`+1 bits wide, so a neighbour sum above one counter's maximum can still trigger.
- R8: `req_valid` is high while the queue holds an entry. `req_row` shows the oldest entry and holds it until a cycle with `req_ready` high. Entries leave in the order they were queued.
- R9: The queue holds `DEPTH` entries. A request that finds no free slot is dropped, the first of a pair having priority, and `overflow` goes high and stays high until reset.
- R10: During and straight after reset, `req_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A row-activate command is issued this cycle |
| act_bank | input | BANK_W | Bank of the activate command |
| act_row | input | ROW_W | Row of the activate command |
| cfg_threshold | input | CNT_W+1 | Activation count that triggers a refresh |
| cfg_window | input | WIN_W | Maintenance window length in cycles |
| req_valid | output | 1 | A refresh request is pending |
| req_ready | input | 1 | Consumer takes the pending request |
| req_row | output | ROW_W | Row to be refreshed |
| overflow | output | 1 | Sticky: a request was dropped |

## Verification
A wrong counter value shows up only indirectly, as a request appearing one activation too early or too late. The sweeps therefore hammer to exactly the threshold and then check that the queue changes on that cycle and on no earlier one. A counter left uncleared after a trigger, after a victim hit or after window expiry shows up as an extra request within fewer than `cfg_threshold` further activations, which the retrigger and window cases provoke on purpose. A counter that wraps instead of saturating shows up as a missing victim request in a sum that needs one counter at its maximum. Queue corruption shows up immediately as a wrong row or order on `req_row`, or as `overflow` set too early, too late, or cleared.

// File: rtl/rrg_pkg.sv
package rrg_pkg;

   localparam int unsigned RRG_MIN_ROWS = 3;
   localparam int unsigned RRG_MIN_CNT_W = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rrg_window.sv
module rrg_window #(
   parameter int WIN_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIN_W-1:0] cfg_window,
   output logic             expire
);

   logic [WIN_W-1:0] tick_q;
   logic [WIN_W:0]   tick_nx;

   assign tick_nx = {1'b0, tick_q} + {{WIN_W{1'b0}}, 1'b1};
   assign expire  = tick_nx >= {1'b0, cfg_window};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q <= '0;
      end else if (expire) begin
         tick_q <= '0;
      end else begin
         tick_q <= tick_nx[WIN_W-1:0];
      end
   end

endmodule

// File: rtl/rrg_count_array.sv
module rrg_count_array #(
   parameter int NUM_ROWS = 64,
   parameter int CNT_W    = 16,
   parameter int ROW_W    = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             expire,
   input  logic                             inc_en,
   input  logic [ROW_W-1:0]                 inc_row,
   input  logic [NUM_ROWS-1:0]              clr_mask,
   output logic [NUM_ROWS-1:0][CNT_W-1:0]   base_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   for (genvar gi = 0; gi < NUM_ROWS; gi++) begin : g_row
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] bumped;
      logic [CNT_W-1:0] cnt_nx;

      assign base_cnt[gi] = expire ? '0 : cnt_q;
      assign bumped = (base_cnt[gi] == CNT_MAX) ? base_cnt[gi]
                                                : base_cnt[gi] + {{(CNT_W-1){1'b0}}, 1'b1};

      always_comb begin
         if (clr_mask[gi]) begin
            cnt_nx = '0;
         end else if (inc_en && (inc_row == ROW_W'(gi))) begin
            cnt_nx = bumped;
         end else begin
            cnt_nx = base_cnt[gi];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_nx;
         end
      end
   end

endmodule

// File: rtl/rrg_detect.sv
module rrg_detect #(
   parameter int NUM_ROWS  = 64,
   parameter int CNT_W     = 16,
   parameter int ROW_W     = 6,
   parameter int BANK_W    = 3,
   parameter int BANK_ID   = 0,
   parameter bit SUM_CHECK = 1'b1
) (
   input  logic                             act_valid,
   input  logic [BANK_W-1:0]                act_bank,
   input  logic [ROW_W-1:0]                 act_row,
   input  logic [CNT_W:0]                   cfg_threshold,
   input  logic [NUM_ROWS-1:0][CNT_W-1:0]   base_cnt,
   output logic                             inc_en,
   output logic [NUM_ROWS-1:0]              clr_mask,
   output logic                             pa_vld,
   output logic [ROW_W-1:0]                 pa_row,
   output logic                             pb_vld,
   output logic [ROW_W-1:0]                 pb_row
);

   localparam logic [ROW_W:0]   LAST_X  = (ROW_W+1)'(NUM_ROWS - 1);
   localparam logic [ROW_W:0]   TWO_X   = (ROW_W+1)'(2);
   localparam logic [ROW_W-1:0] ONE_R   = ROW_W'(1);
   localparam logic [ROW_W-1:0] TWO_R   = ROW_W'(2);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [ROW_W:0]   row_x;
   logic             hit;
   logic             has_lo, has_hi, has_lo2, has_hi2;
   logic [ROW_W-1:0] idx_lo, idx_hi, idx_lo2, idx_hi2;
   logic [CNT_W-1:0] own_cnt, cur_cnt;
   logic [CNT_W:0]   cur_x;
   logic             aggr;
   logic             vic_lo, vic_hi;

   assign row_x   = {1'b0, act_row};
   assign hit     = act_valid && (act_bank == BANK_W'(BANK_ID)) && (row_x <= LAST_X);
   assign has_lo  = act_row != '0;
   assign has_hi  = row_x < LAST_X;
   assign has_lo2 = row_x >= TWO_X;
   assign has_hi2 = (row_x + TWO_X) <= LAST_X;
   assign idx_lo  = act_row - ONE_R;
   assign idx_hi  = act_row + ONE_R;
   assign idx_lo2 = act_row - TWO_R;
   assign idx_hi2 = act_row + TWO_R;

   assign own_cnt = hit ? base_cnt[act_row] : '0;
   assign cur_cnt = (own_cnt == CNT_MAX) ? own_cnt : own_cnt + {{(CNT_W-1){1'b0}}, 1'b1};
   assign cur_x   = {1'b0, cur_cnt};
   assign aggr    = hit && (cur_x >= cfg_threshold);

   if (SUM_CHECK) begin : g_sum
      logic [CNT_W-1:0] far_lo, far_hi;
      logic [CNT_W:0]   sum_lo, sum_hi;

      assign far_lo = (hit && has_lo2) ? base_cnt[idx_lo2] : '0;
      assign far_hi = (hit && has_hi2) ? base_cnt[idx_hi2] : '0;
      assign sum_lo = {1'b0, far_lo} + cur_x;
      assign sum_hi = {1'b0, far_hi} + cur_x;
      assign vic_lo = hit && !aggr && has_lo && (sum_lo >= cfg_threshold);
      assign vic_hi = hit && !aggr && has_hi && (sum_hi >= cfg_threshold);
   end else begin : g_nosum
      assign vic_lo = 1'b0;
      assign vic_hi = 1'b0;
   end

   assign inc_en = hit;
   assign pa_vld = (aggr && has_lo) || vic_lo;
   assign pa_row = idx_lo;
   assign pb_vld = (aggr && has_hi) || vic_hi;
   assign pb_row = idx_hi;

   always_comb begin
      clr_mask = '0;
      for (int i = 0; i < NUM_ROWS; i++) begin
         if ((aggr || vic_lo || vic_hi) && (act_row == ROW_W'(i))) begin
            clr_mask[i] = 1'b1;
         end
         if (vic_lo && has_lo2 && (idx_lo2 == ROW_W'(i))) begin
            clr_mask[i] = 1'b1;
         end
         if (vic_hi && has_hi2 && (idx_hi2 == ROW_W'(i))) begin
            clr_mask[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/rrg_req_fifo.sv
module rrg_req_fifo #(
   parameter int DEPTH = 4,
   parameter int ROW_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wa_vld,
   input  logic [ROW_W-1:0] wa_row,
   input  logic             wb_vld,
   input  logic [ROW_W-1:0] wb_row,
   output logic             rd_vld,
   output logic [ROW_W-1:0] rd_row,
   input  logic             rd_rdy,
   output logic             ovf
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int OCC_W = $clog2(DEPTH + 1);

   logic [ROW_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [OCC_W-1:0] occ_q, free_slots, n_req, n_acc;
   logic [ROW_W-1:0] e0, e1;
   logic             drop, pop;
   logic             ovf_q;

   always_comb begin
      if (wa_vld) begin
         e0 = wa_row;
         e1 = wb_row;
      end else begin
         e0 = wb_row;
         e1 = wb_row;
      end
   end

   assign n_req      = OCC_W'(wa_vld) + OCC_W'(wb_vld);
   assign free_slots = OCC_W'(DEPTH) - occ_q;
   assign drop       = n_req > free_slots;
   assign n_acc      = drop ? free_slots : n_req;
   assign pop        = rd_rdy && (occ_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         occ_q <= '0;
         ovf_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '0;
         end
      end else begin
         if (n_acc != '0) begin
            mem[wp_q] <= e0;
         end
         if (n_acc == OCC_W'(2)) begin
            mem[wp_q + PTR_W'(1)] <= e1;
         end
         wp_q  <= wp_q + PTR_W'(n_acc);
         rp_q  <= rp_q + PTR_W'(pop);
         occ_q <= occ_q + n_acc - OCC_W'(pop);
         ovf_q <= ovf_q | drop;
      end
   end

   assign rd_vld = occ_q != '0;
   assign rd_row = mem[rp_q];
   assign ovf    = ovf_q;

endmodule

// File: rtl/row_refresh_guard.sv
module row_refresh_guard #(
   parameter int NUM_ROWS  = 64,
   parameter int CNT_W     = 16,
   parameter int WIN_W     = 26,
   parameter int DEPTH     = 4,
   parameter int BANK_W    = 3,
   parameter int BANK_ID   = 0,
   parameter bit SUM_CHECK = 1'b1,
   localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_valid,
   input  logic [BANK_W-1:0] act_bank,
   input  logic [ROW_W-1:0]  act_row,
   input  logic [CNT_W:0]    cfg_threshold,
   input  logic [WIN_W-1:0]  cfg_window,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ROW_W-1:0]  req_row,
   output logic              overflow
);

   if (NUM_ROWS < int'(rrg_pkg::RRG_MIN_ROWS)) begin : g_err_rows
      $error("row_refresh_guard: NUM_ROWS must be at least 3");
   end
   if (CNT_W < int'(rrg_pkg::RRG_MIN_CNT_W)) begin : g_err_cnt
      $error("row_refresh_guard: CNT_W must be at least 2");
   end
   if ((DEPTH < 2) || !rrg_pkg::is_pow2(DEPTH)) begin : g_err_depth
      $error("row_refresh_guard: DEPTH must be a power of two of at least 2");
   end
   if ((BANK_ID < 0) || (BANK_ID >= (1 << BANK_W))) begin : g_err_bank
      $error("row_refresh_guard: BANK_ID does not fit in BANK_W bits");
   end
   if (WIN_W < 1) begin : g_err_win
      $error("row_refresh_guard: WIN_W must be positive");
   end

   logic                           expire;
   logic                           inc_en;
   logic [NUM_ROWS-1:0]            clr_mask;
   logic [NUM_ROWS-1:0][CNT_W-1:0] base_cnt;
   logic                           pa_vld, pb_vld;
   logic [ROW_W-1:0]               pa_row, pb_row;

   rrg_window #(
      .WIN_W (WIN_W)
   ) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_window (cfg_window),
      .expire     (expire)
   );

   rrg_count_array #(
      .NUM_ROWS (NUM_ROWS),
      .CNT_W    (CNT_W),
      .ROW_W    (ROW_W)
   ) u_counts (
      .clk      (clk),
      .rst_n    (rst_n),
      .expire   (expire),
      .inc_en   (inc_en),
      .inc_row  (act_row),
      .clr_mask (clr_mask),
      .base_cnt (base_cnt)
   );

   rrg_detect #(
      .NUM_ROWS  (NUM_ROWS),
      .CNT_W     (CNT_W),
      .ROW_W     (ROW_W),
      .BANK_W    (BANK_W),
      .BANK_ID   (BANK_ID),
      .SUM_CHECK (SUM_CHECK)
   ) u_detect (
      .act_valid     (act_valid),
      .act_bank      (act_bank),
      .act_row       (act_row),
      .cfg_threshold (cfg_threshold),
      .base_cnt      (base_cnt),
      .inc_en        (inc_en),
      .clr_mask      (clr_mask),
      .pa_vld        (pa_vld),
      .pa_row        (pa_row),
      .pb_vld        (pb_vld),
      .pb_row        (pb_row)
   );

   rrg_req_fifo #(
      .DEPTH (DEPTH),
      .ROW_W (ROW_W)
   ) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .wa_vld (pa_vld),
      .wa_row (pa_row),
      .wb_vld (pb_vld),
      .wb_row (pb_row),
      .rd_vld (req_valid),
      .rd_row (req_row),
      .rd_rdy (req_ready),
      .ovf    (overflow)
   );

endmodule

// File: rtl/rrg_checker.sv
module rrg_checker #(
   parameter int NUM_ROWS = 64,
   parameter int BANK_W   = 3,
   parameter int BANK_ID  = 0,
   parameter int ROW_W    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              act_valid,
   input logic [BANK_W-1:0] act_bank,
   input logic [ROW_W-1:0]  act_row,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ROW_W-1:0]  req_row,
   input logic              overflow
);

   // R9: once set, the drop flag stays set
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R9: a drop needs an activation in the cycle before
   a_r9_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> $past(act_valid));

   // R8: a stalled request keeps its row
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_row)));

   // R3: no request outside the bank
   a_r3_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (int'(req_row) < NUM_ROWS));

   // R5: foreign or out-of-range activations queue nothing
   a_r5_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && act_valid &&
       ((act_bank != BANK_W'(BANK_ID)) || (int'(act_row) >= NUM_ROWS))) |=> !req_valid);

   // R1: no request appears without an activation
   a_r1_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !act_valid) |=> !req_valid);

endmodule

bind row_refresh_guard rrg_checker #(
   .NUM_ROWS (NUM_ROWS),
   .BANK_W   (BANK_W),
   .BANK_ID  (BANK_ID),
   .ROW_W    (ROW_W)
) i_rrg_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .act_valid (act_valid),
   .act_bank  (act_bank),
   .act_row   (act_row),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_row   (req_row),
   .overflow  (overflow)
);

// File: tb/test_row_refresh_guard.sv
module test_row_refresh_guard;

   localparam int NR    = 6;
   localparam int CW    = 8;
   localparam int WW    = 16;
   localparam int DP    = 4;
   localparam int BW    = 2;
   localparam int BID   = 1;
   localparam int RW    = 3;
   localparam int WBIG  = 65535;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act_valid = 1'b0;
   logic [BW-1:0] act_bank = '0;
   logic [RW-1:0] act_row = '0;
   logic [CW:0]   cfg_threshold = '0;
   logic [WW-1:0] cfg_window = '0;
   logic          req_valid;
   logic          req_ready = 1'b0;
   logic [RW-1:0] req_row;
   logic          overflow;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   row_refresh_guard #(
      .NUM_ROWS (NR),
      .CNT_W    (CW),
      .WIN_W    (WW),
      .DEPTH    (DP),
      .BANK_W   (BW),
      .BANK_ID  (BID)
   ) i_row_refresh_guard (
      .clk           (clk),
      .rst_n         (rst_n),
      .act_valid     (act_valid),
      .act_bank      (act_bank),
      .act_row       (act_row),
      .cfg_threshold (cfg_threshold),
      .cfg_window    (cfg_window),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_row       (req_row),
      .overflow      (overflow)
   );

   task automatic chk(input bit ok, input string tag, input int actual, input int expected);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic apply_reset(input int thr, input int win);
      @(negedge clk);
      rst_n = 1'b0;
      act_valid = 1'b0;
      req_ready = 1'b0;
      cfg_threshold = (CW+1)'(thr);
      cfg_window = WW'(win);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic hit_row(input int bank, input int row, input int times);
      for (int k = 0; k < times; k++) begin
         act_valid = 1'b1;
         act_bank = BW'(bank);
         act_row = RW'(row);
         @(negedge clk);
         act_valid = 1'b0;
      end
   endtask

   task automatic expect_pop(input int row, input string tag);
      chk(req_valid === 1'b1, {tag, " valid"}, int'(req_valid), 1);
      chk(int'(req_row) == row, {tag, " row"}, int'(req_row), row);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
   endtask

   task automatic expect_idle(input string tag);
      chk(req_valid === 1'b0, {tag, " idle"}, int'(req_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R10: reset state
      apply_reset(3, WBIG);
      chk(req_valid === 1'b0, "R10 req_valid", int'(req_valid), 0);
      chk(overflow === 1'b0, "R10 overflow", int'(overflow), 0);

      // R1 / R3: sweep every row as aggressor, threshold 3
      for (int r = 0; r < NR; r++) begin
         apply_reset(3, WBIG);
         hit_row(BID, r, 2);
         expect_idle("R1 below threshold");
         hit_row(BID, r, 1);
         if (r > 0) expect_pop(r - 1, "R1 lower neighbour");
         if (r < NR - 1) expect_pop(r + 1, "R1 upper neighbour");
         expect_idle("R3 no extra neighbour");
      end

      // R2: count cleared after trigger
      apply_reset(3, WBIG);
      hit_row(BID, 2, 3);
      expect_pop(1, "R2 first trigger");
      expect_pop(3, "R2 first trigger");
      hit_row(BID, 2, 2);
      expect_idle("R2 no early retrigger");
      hit_row(BID, 2, 1);
      expect_pop(1, "R2 retrigger");
      expect_pop(3, "R2 retrigger");

      // R4: two-sided victim and clearing of its neighbours
      apply_reset(4, WBIG);
      hit_row(BID, 1, 2);
      hit_row(BID, 3, 1);
      expect_idle("R4 sum below threshold");
      hit_row(BID, 3, 1);
      expect_pop(2, "R4 victim");
      expect_idle("R4 single victim");
      hit_row(BID, 1, 2);
      expect_idle("R4 neighbours cleared");

      // R5: foreign bank and out-of-range rows
      apply_reset(2, WBIG);
      hit_row(0, 2, 3);
      hit_row(3, 2, 3);
      expect_idle("R5 foreign bank");
      hit_row(BID, 6, 3);
      hit_row(BID, 7, 3);
      expect_idle("R5 out of range row");
      hit_row(BID, 2, 1);
      expect_idle("R5 count untouched");
      hit_row(BID, 2, 1);
      expect_pop(1, "R5 own bank");
      expect_pop(3, "R5 own bank");

      // R6: window expiry clears counts
      apply_reset(3, 40);
      hit_row(BID, 2, 2);
      repeat (50) @(negedge clk);
      hit_row(BID, 2, 1);
      expect_idle("R6 cleared by window");
      hit_row(BID, 2, 2);
      expect_pop(1, "R6 new window");
      expect_pop(3, "R6 new window");

      // R7: saturation, sum above one counter maximum
      apply_reset(510, WBIG);
      hit_row(BID, 4, 300);
      expect_idle("R7 saturated alone");
      hit_row(BID, 2, 254);
      expect_idle("R7 sum below");
      hit_row(BID, 2, 1);
      expect_pop(3, "R7 saturated sum");
      expect_idle("R7 after victim");

      // R8 / R9: queue order, hold, drop and sticky flag
      apply_reset(1, WBIG);
      hit_row(BID, 2, 1);
      hit_row(BID, 0, 1);
      chk(overflow === 1'b0, "R9 no drop yet", int'(overflow), 0);
      hit_row(BID, 3, 1);
      chk(overflow === 1'b1, "R9 drop flagged", int'(overflow), 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(req_valid === 1'b1 && int'(req_row) == 1, "R8 hold head", int'(req_row), 1);
      end
      expect_pop(1, "R8 order");
      expect_pop(3, "R8 order");
      expect_pop(1, "R8 order");
      expect_pop(2, "R9 first of pair kept");
      expect_idle("R9 second of pair dropped");
      chk(overflow === 1'b1, "R9 sticky", int'(overflow), 1);
      apply_reset(1, WBIG);
      chk(overflow === 1'b0, "R10 flag cleared", int'(overflow), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule